// File: doc/BRIEF.md
# Cascadable Line-Sensor Scan Sequencer

This block models the digital readout sequencing of one die in a chain of linear image sensors. A global start pulse, shared by every die in the chain, starts a fixed pre-scan period of dummy clocks on all dies at once. Then the die either starts its active readout by itself (the head of the chain) or waits for a local start pulse. That local pulse comes from the end-of-scan output of the die before it.

During active readout the block gives one pixel index per clock and raises a pixel-active flag and an output-amplifier enable. In full-resolution mode it reads every element. In half-resolution mode it reads adjacent pairs (elements 1+2, 3+4, ...), so the scan has half as many pixels. A fixed number of clocks before its last pixel, the block sends a single-clock end-of-scan pulse. The next die then puts out its first pixel in the clock right after this die's last pixel, with no gap. A global start that is held high across two sampling edges is reported as a protocol violation.

All inputs are sampled on the block's active clock edge. This edge stands for the falling clock edge at which a real die loads its shift register.

Top module: `csq_scan_seq`

## Requirements
- R1: A global start sampled high starts the pre-scan phase in the next cycle (clock 1). Clocks 1 to 82 are dummy pixels, with pix_valid low.
- R2: With first_sel high, the first active pixel (index 1) appears in clock 83 after the global start was captured.
- R3: With res_full high, 344 active pixels come out on consecutive clocks, with pix_idx counting 1 to 344. The last one is in clock 426.
- R4: With res_full low, 172 paired pixels come out on consecutive clocks, with pix_idx counting 1 to 172. The last one is in clock 254.
- R5: eos_out is a single-clock pulse in the cycle of active pixel N-10, where N is the active pixel count. For the head die this is clock 416 in full mode and clock 244 in half mode.
- R6: With first_sel low, the die stays inactive after the pre-scan phase until si_in is high. If si_in is high in cycle c, pixel 1 appears in cycle c+11, directly after the predecessor's last pixel.
- R7: si_in has no effect when first_sel is high, or when the die is not waiting after its pre-scan phase.
- R8: amp_en is high exactly in the cycles in which pix_valid is high, and low at all other times.
- R9: If gst_in is sampled high on two consecutive edges, start_err is high for one cycle after the second sample. Each high sample reloads the start.
- R10: A global start captured during a scan aborts that scan and restarts the pre-scan phase. Starts are not queued.
- R11: After the last active pixel the block goes idle with pix_valid and amp_en low. The straps are latched at start capture, so changing them mid-scan has no effect on the running scan.
- R12: After a synchronous reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| gst_in | input | 1 | Global start, shared by all dies of a chain |
| si_in | input | 1 | Local start, from the predecessor's eos_out |
| first_sel | input | 1 | Strap: 1 = head of chain (self-start), 0 = chained |
| res_full | input | 1 | Strap: 1 = full resolution, 0 = paired half resolution |
| pix_idx | output | 9 | Index of the active pixel (1-based), 0 when inactive |
| pix_valid | output | 1 | Active pixel is being driven |
| amp_en | output | 1 | Output amplifier enable |
| eos_out | output | 1 | End-of-scan handoff pulse for the next die |
| start_err | output | 1 | Global start held across two sampling edges |

## Verification
The bench counts clocks from each global start and checks the edges of the scan timing:
- Clock 83 for the first active pixel. A design that is off by one in the dummy counter would start one clock early or late.
- Clocks 416 and 244 for the handoff pulse. A wrong lead would leave a gap or an overlap between dies.
- Exactly eleven cycles from the local start to pixel 1 on a chained die. A missing arm phase would make the die collide with its predecessor.

It also sends local starts at times when they must be ignored, changes a strap in the middle of a scan, holds the global start across two edges, and restarts the sequence mid-scan. A design that queues starts, follows a strap live, or takes a local start early would then give the wrong pixel count or the wrong start clock.

// File: rtl/csq_pkg.sv
package csq_pkg;

    localparam int unsigned CSQ_DUMMY_DEF = 82;
    localparam int unsigned CSQ_FULL_DEF  = 344;
    localparam int unsigned CSQ_LEAD_DEF  = 10;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_WAIT = 3'd2,
        ST_ARM  = 3'd3,
        ST_ACT  = 3'd4
    } csq_state_e;

    typedef struct packed {
        logic full_res;
        logic self_start;
    } csq_cfg_t;

    function automatic int unsigned scan_len(int unsigned full_len, logic full_res);
        return full_res ? full_len : (full_len / 2);
    endfunction

endpackage

// File: rtl/csq_start_ctl.sv
module csq_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic gst_in,
    output logic load,
    output logic hold_err
);
    logic gst_q;

    assign load = gst_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            gst_q    <= 1'b0;
            hold_err <= 1'b0;
        end else begin
            gst_q    <= gst_in;
            hold_err <= gst_in & gst_q;
        end
    end

    // R9: an error pulse never stands alone after a low sample
    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        hold_err |-> $past(gst_in));
endmodule

// File: rtl/csq_phase_fsm.sv
module csq_phase_fsm
    import csq_pkg::*;
#(
    parameter int unsigned DUMMY_CLKS = CSQ_DUMMY_DEF,
    parameter int unsigned PIX_FULL   = CSQ_FULL_DEF,
    parameter int unsigned LEAD_CLKS  = CSQ_LEAD_DEF,
    parameter int unsigned CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             si,
    input  csq_cfg_t         cfg_in,
    output csq_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output csq_cfg_t         cfg
);
    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS);
    localparam logic [CNT_W-1:0] LEAD_LAST  = CNT_W'(LEAD_CLKS);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    logic [CNT_W-1:0] act_last;
    assign act_last = CNT_W'(scan_len(PIX_FULL, cfg.full_res));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cfg   <= '0;
        end else if (load) begin
            state <= ST_PRE;
            cnt   <= ONE;
            cfg   <= cfg_in;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                end
                ST_PRE: begin
                    if (cnt == DUMMY_LAST) begin
                        state <= cfg.self_start ? ST_ACT : ST_WAIT;
                        cnt   <= cfg.self_start ? ONE : '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                ST_WAIT: begin
                    if (si) begin
                        state <= ST_ARM;
                        cnt   <= ONE;
                    end
                end
                ST_ARM: begin
                    if (cnt == LEAD_LAST) begin
                        state <= ST_ACT;
                        cnt   <= ONE;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                ST_ACT: begin
                    if (cnt == act_last) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R10: any captured start restarts the pre-scan phase
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == ST_PRE && cnt == ONE));

    // R2: the head die moves to pixel 1 right after the last dummy clock
    p_selfstart_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && state == ST_PRE && cnt == DUMMY_LAST && cfg.self_start)
        |=> (state == ST_ACT && cnt == ONE));

    // R6: a chained die holds in the wait phase until its local start
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && state == ST_WAIT && !si) |=> (state == ST_WAIT));

    // R11: the scan ends in idle after its last pixel
    p_end_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!load && state == ST_ACT && cnt == act_last) |=> (state == ST_IDLE));
endmodule

// File: rtl/csq_out_stage.sv
module csq_out_stage
    import csq_pkg::*;
#(
    parameter int unsigned PIX_FULL  = CSQ_FULL_DEF,
    parameter int unsigned LEAD_CLKS = CSQ_LEAD_DEF,
    parameter int unsigned CNT_W     = 9,
    parameter int unsigned IDX_W     = 9
) (
    input  csq_state_e       state,
    input  logic [CNT_W-1:0] cnt,
    input  csq_cfg_t         cfg,
    output logic [IDX_W-1:0] pix_idx,
    output logic             pix_valid,
    output logic             amp_en,
    output logic             eos
);
    logic [CNT_W-1:0] eos_pos;
    logic             in_act;

    assign eos_pos = CNT_W'(scan_len(PIX_FULL, cfg.full_res) - LEAD_CLKS);
    assign in_act  = (state == ST_ACT);

    always_comb begin
        pix_valid = in_act;
        amp_en    = in_act;
        pix_idx   = in_act ? IDX_W'(cnt) : '0;
        eos       = in_act && (cnt == eos_pos);
    end
endmodule

// File: rtl/csq_scan_seq.sv
module csq_scan_seq
    import csq_pkg::*;
#(
    parameter int unsigned DUMMY_CLKS = CSQ_DUMMY_DEF,
    parameter int unsigned PIX_FULL   = CSQ_FULL_DEF,
    parameter int unsigned LEAD_CLKS  = CSQ_LEAD_DEF,
    localparam int unsigned IDX_W     = $clog2(PIX_FULL + 1),
    localparam int unsigned CNT_MAX   = (DUMMY_CLKS > PIX_FULL) ? DUMMY_CLKS : PIX_FULL,
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gst_in,
    input  logic             si_in,
    input  logic             first_sel,
    input  logic             res_full,
    output logic [IDX_W-1:0] pix_idx,
    output logic             pix_valid,
    output logic             amp_en,
    output logic             eos_out,
    output logic             start_err
);
    logic             load;
    csq_state_e       state;
    logic [CNT_W-1:0] cnt;
    csq_cfg_t         cfg_in, cfg;

    assign cfg_in = '{full_res: res_full, self_start: first_sel};

    csq_start_ctl u_start (
        .clk      (clk),
        .rst      (rst),
        .gst_in   (gst_in),
        .load     (load),
        .hold_err (start_err)
    );

    csq_phase_fsm #(
        .DUMMY_CLKS (DUMMY_CLKS),
        .PIX_FULL   (PIX_FULL),
        .LEAD_CLKS  (LEAD_CLKS),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .si     (si_in),
        .cfg_in (cfg_in),
        .state  (state),
        .cnt    (cnt),
        .cfg    (cfg)
    );

    csq_out_stage #(
        .PIX_FULL  (PIX_FULL),
        .LEAD_CLKS (LEAD_CLKS),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_out (
        .state     (state),
        .cnt       (cnt),
        .cfg       (cfg),
        .pix_idx   (pix_idx),
        .pix_valid (pix_valid),
        .amp_en    (amp_en),
        .eos       (eos_out)
    );

    // R5: the handoff pulse lasts one clock
    p_eos_single_r5: assert property (@(posedge clk) disable iff (rst)
        eos_out |=> !eos_out);

    // R5: the handoff pulse lands on pixel N-10
    p_eos_pos_r5: assert property (@(posedge clk) disable iff (rst)
        eos_out |-> (pix_valid &&
            pix_idx == IDX_W'(scan_len(PIX_FULL, cfg.full_res) - LEAD_CLKS)));

    // R8: amplifier powered only while a pixel is driven
    p_amp_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |-> !amp_en);

    // R3: index stays inside the active range
    p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (pix_idx >= IDX_W'(1) && pix_idx <= IDX_W'(PIX_FULL)));

    // R9: a start held over two samples raises the error flag
    p_hold_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (gst_in ##1 gst_in) |=> start_err);
endmodule

// File: tb/tb_csq_scan_seq.sv
module tb_csq_scan_seq;
    logic       clk = 1'b0;
    logic       rst, gst_in, si_in, first_sel, res_full;
    logic [8:0] pix_idx;
    logic       pix_valid, amp_en, eos_out, start_err;

    int n_tests = 0, n_fail = 0;
    int cyc, first_v, last_v, nvalid, seq_err, amp_err, eos_cnt, eos_cyc, eos_idx, exp_next;
    bit finished = 0;

    always #5 clk = ~clk;

    csq_scan_seq dut (
        .clk(clk), .rst(rst), .gst_in(gst_in), .si_in(si_in),
        .first_sel(first_sel), .res_full(res_full), .pix_idx(pix_idx),
        .pix_valid(pix_valid), .amp_en(amp_en), .eos_out(eos_out),
        .start_err(start_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic clear_obs();
        first_v = -1; last_v = -1; nvalid = 0; seq_err = 0; amp_err = 0;
        eos_cnt = 0; eos_cyc = -1; eos_idx = -1; exp_next = 1;
    endtask

    task automatic observe(input int n);
        for (int i = 0; i < n; i++) begin
            if (pix_valid) begin
                if (first_v < 0) first_v = cyc;
                last_v = cyc;
                nvalid++;
                if (int'(pix_idx) != exp_next) seq_err++;
                exp_next++;
            end
            if (amp_en != pix_valid) amp_err++;
            if (eos_out) begin
                eos_cnt++;
                eos_cyc = cyc;
                eos_idx = int'(pix_idx);
            end
            step();
        end
    endtask

    task automatic pulse_gst();
        cyc = 0;
        gst_in = 1'b1;
        step();
        gst_in = 1'b0;
        clear_obs();
    endtask

    task automatic t_reset();
        check(pix_valid == 0 && amp_en == 0 && eos_out == 0 && start_err == 0 && pix_idx == 0,
              "R12 reset outputs", int'(pix_valid) + int'(amp_en) + int'(eos_out) + int'(pix_idx), 0);
    endtask

    task automatic t_head(input bit full);
        int n;
        n = full ? 344 : 172;
        first_sel = 1'b1; res_full = full;
        pulse_gst();
        observe(82 + n + 5);
        check(first_v == 83, "R1/R2 first active clock", first_v, 83);
        check(nvalid == n && seq_err == 0, full ? "R3 full pixel run" : "R4 half pixel run", nvalid, n);
        check(last_v == 82 + n, full ? "R3 last pixel clock" : "R4 last pixel clock", last_v, 82 + n);
        check(eos_cnt == 1 && eos_cyc == 82 + n - 10, "R5 eos clock", eos_cyc, 82 + n - 10);
        check(eos_idx == n - 10, "R5 eos pixel", eos_idx, n - 10);
        check(amp_err == 0, "R8 amp follows valid", amp_err, 0);
        check(pix_valid == 0 && amp_en == 0, "R11 idle after scan", int'(pix_valid) + int'(amp_en), 0);
    endtask

    task automatic t_chained();
        int c;
        first_sel = 1'b0; res_full = 1'b1;
        pulse_gst();
        observe(40);
        si_in = 1'b1; observe(1); si_in = 1'b0;
        observe(100);
        check(nvalid == 0, "R6/R7 chained die waits, early si ignored", nvalid, 0);
        c = cyc;
        si_in = 1'b1; observe(1); si_in = 1'b0;
        observe(344 + 20);
        check(first_v == c + 11, "R6 pixel 1 eleven cycles after si", first_v, c + 11);
        check(nvalid == 344 && seq_err == 0, "R6 chained pixel run", nvalid, 344);
        check(eos_cyc == c + 11 + 333, "R5 chained eos clock", eos_cyc, c + 11 + 333);
        check(amp_err == 0, "R8 chained amp", amp_err, 0);
    endtask

    task automatic t_si_ignored_head();
        first_sel = 1'b1; res_full = 1'b1;
        pulse_gst();
        observe(150);
        si_in = 1'b1; observe(1); si_in = 1'b0;
        observe(300);
        check(first_v == 83 && nvalid == 344 && seq_err == 0, "R7 si ignored on head die", nvalid, 344);
    endtask

    task automatic t_hold();
        first_sel = 1'b1; res_full = 1'b0;
        cyc = 0;
        gst_in = 1'b1;
        step();
        check(start_err == 0, "R9 no error after single sample", start_err, 0);
        step();
        gst_in = 1'b0;
        check(start_err == 1, "R9 error after second sample", start_err, 1);
        clear_obs();
        observe(1);
        check(start_err == 0, "R9 error is one cycle", start_err, 0);
        observe(82 + 172 + 5);
        check(first_v == 84 && nvalid == 172, "R9 second sample reloads start", first_v, 84);
    endtask

    task automatic t_restart();
        first_sel = 1'b1; res_full = 1'b1;
        pulse_gst();
        observe(200);
        pulse_gst();
        observe(150);
        res_full = 1'b0;
        first_sel = 1'b0;
        observe(82 + 344 + 5 - 150);
        check(first_v == 83, "R10 restart begins dummy phase again", first_v, 83);
        check(nvalid == 344 && seq_err == 0, "R11 straps latched at start", nvalid, 344);
        res_full = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; gst_in = 1'b0; si_in = 1'b0; first_sel = 1'b1; res_full = 1'b1;
        cyc = 0;
        clear_obs();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_head(1'b1);
        t_head(1'b0);
        t_chained();
        t_si_ignored_head();
        t_hold();
        t_restart();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule